// File: doc/BRIEF.md
# Level-Sensitive External Interrupt Aggregator

This block watches a group of active-low external pins and folds them into one interrupt request for the processor. Each pin has its own enable bit. When any enabled pin sits at a low level, one shared pending flag is set. The interrupt request output is a direct copy of that flag. The flag is sticky: it stays set until software writes a zero to it, even if the pins that caused it are disabled in the meantime. The flag also sets again at once while an enabled pin is still low.

Software reaches the block through a small register port. The port has a single-cycle write strobe, one address bit and an 8-bit data bus, and the read data is combinational. Each pin passes through a two-flop synchroniser before it is checked. A separate wake output is built from the raw pins without any clock, so the chip can leave its clock-halted stop mode when an enabled pin goes low.

Top module: `lvl_irq_agg`

## Requirements
- R1: While reset is held, and once it is released, the enable register reads 0, the flag reads 0, and `irq_o` is 0.
- R2: Address 0 holds the 8-bit enable register, which can be written and read back. Bit n of this register enables pin n. Address 1 is the status register. Bit 0 of the status register is the flag, and bits 7:1 read as 0. A write takes effect on the rising edge at which `wr_en_i` is 1.
- R3: A pin whose enable bit is 0 never sets the flag, however long it is held low.
- R4: An enabled pin held low sets the flag, and `irq_o` equals the flag. If the pin goes low just after rising edge 0, `irq_o` is still 0 after edge 2 and is 1 after edge 3 (two synchroniser stages plus the flag register).
- R5: A write to the status register with data bit 0 equal to 1 leaves the flag unchanged.
- R6: A write to the status register with data bit 0 equal to 0 clears the flag at that edge, provided no enabled synchronised pin is low.
- R7: Once set, the flag and `irq_o` stay at 1 even after every enable bit is cleared, until software clears the flag.
- R8: `wake_o` is 1 whenever any enabled raw pin is low or the flag is 1. It is combinational and needs no clock edge.
- R9: When a software clear and an enabled low pin fall on the same edge, setting wins, so the flag stays 1 for as long as an enabled pin remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| pin_n_i | input | 8 | External active-low interrupt pins, asynchronous to the clock |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| addr_i | input | 1 | Register select: 0 = enable register, 1 = status register |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Interrupt request to the processor; a copy of the flag |
| wake_o | output | 1 | Clock-free wake request for leaving stop mode |

## Verification
Single enabled pins are driven low with the timing measured edge by edge. This separates a correct three-edge path from a shorter or longer synchroniser. Low levels on disabled pins, including several at once next to enabled high pins, show that the enable mask is applied per bit. Clear writes are issued with the cause removed, with the cause still present, and after the enables have been dropped. These cases tell a sticky, set-priority flag apart from one that clears too early or follows the pins. Finally, the clock is stopped while a pin falls, to show that the wake path does not depend on any register.

// File: rtl/lia_pkg.sv
package lia_pkg;
  localparam int unsigned LIA_DATA_W = 8;

  typedef enum logic {
    LIA_SEL_ENABLE = 1'b0,
    LIA_SEL_STATUS = 1'b1
  } lia_sel_e;

  localparam int unsigned LIA_FLAG_BIT = 0;
endpackage

// File: rtl/lia_rst_sync.sv
module lia_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lia_pin_sync.sv
module lia_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] stage_q;
    logic [STAGES-1:0] stage_d;

    always_comb begin
      stage_d = {stage_q[STAGES-2:0], din[g]};
    end

    // Idle level of an active-low pin is high.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '1;
      end else begin
        stage_q <= stage_d;
      end
    end

    assign dout[g] = stage_q[STAGES-1];
  end
endmodule

// File: rtl/lia_regs.sv
module lia_regs
  import lia_pkg::*;
#(
  parameter int unsigned WIDTH = LIA_DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             flag,
  output logic [WIDTH-1:0] enable_q,
  output logic             clr_req,
  output logic [WIDTH-1:0] rdata
);
  logic             enable_we;
  logic [WIDTH-1:0] enable_d;

  always_comb begin
    enable_we = wr_en && (lia_sel_e'(addr) == LIA_SEL_ENABLE);
    enable_d  = enable_we ? wdata : enable_q;
    clr_req   = wr_en && (lia_sel_e'(addr) == LIA_SEL_STATUS) && !wdata[LIA_FLAG_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
    end else begin
      enable_q <= enable_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (lia_sel_e'(addr) == LIA_SEL_ENABLE) begin
      rdata = enable_q;
    end else begin
      rdata[LIA_FLAG_BIT] = flag;
    end
  end
endmodule

// File: rtl/lia_flag.sv
module lia_flag #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_sync_n,
  input  logic [WIDTH-1:0] enable,
  input  logic             clr_req,
  output logic             hit,
  output logic             flag_q
);
  logic flag_d;

  always_comb begin
    hit = |(~pin_sync_n & enable);
    // Setting wins over a clear on the same edge.
    if (hit) begin
      flag_d = 1'b1;
    end else if (clr_req) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg
  import lia_pkg::*;
#(
  parameter int unsigned N_PINS      = LIA_DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_n_i,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic              rst_n_int;
  logic [N_PINS-1:0] pin_sync_n;
  logic [N_PINS-1:0] enable_q;
  logic              clr_req;
  logic              hit;
  logic              flag_q;

  lia_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lia_pin_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (pin_n_i),
    .dout  (pin_sync_n)
  );

  lia_regs #(.WIDTH(N_PINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (wr_en_i),
    .addr     (addr_i),
    .wdata    (wdata_i),
    .flag     (flag_q),
    .enable_q (enable_q),
    .clr_req  (clr_req),
    .rdata    (rdata_o)
  );

  lia_flag #(.WIDTH(N_PINS)) u_flag (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .pin_sync_n (pin_sync_n),
    .enable     (enable_q),
    .clr_req    (clr_req),
    .hit        (hit),
    .flag_q     (flag_q)
  );

  assign irq_o  = flag_q;
  // Clock-free path for leaving stop mode.
  assign wake_o = (|(~pin_n_i & enable_q)) | flag_q;
endmodule

// File: rtl/lia_checker.sv
module lia_checker #(
  parameter int unsigned N_PINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_PINS-1:0] pin_n,
  input logic [N_PINS-1:0] enable,
  input logic              wr_en,
  input logic              addr,
  input logic [N_PINS-1:0] wdata,
  input logic              hit,
  input logic              irq,
  input logic              wake
);
  logic clr_wr;
  logic one_wr;
  assign clr_wr = wr_en && addr && !wdata[0];
  assign one_wr = wr_en && addr && wdata[0];

  a_r4_enabled_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq);

  a_r3_no_set_without_enabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !hit) |=> !irq);

  a_r5_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (one_wr && irq) |=> irq);

  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !hit) |=> !irq);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && hit) |=> irq);

  // R8: wake follows the flag and the enabled raw pins without a clock.
  always_comb begin
    if (rst_n) begin
      a_r8_wake_covers: assert (wake == ((|(~pin_n & enable)) || irq));
    end
  end
endmodule

bind lvl_irq_agg lia_checker #(.N_PINS(N_PINS)) u_lia_checker (
  .clk    (clk),
  .rst_n  (rst_n_int),
  .pin_n  (pin_n_i),
  .enable (enable_q),
  .wr_en  (wr_en_i),
  .addr   (addr_i),
  .wdata  (wdata_i),
  .hit    (hit),
  .irq    (irq_o),
  .wake   (wake_o)
);

// File: tb/test_lvl_irq_agg.sv
`timescale 1ns/1ps
module test_lvl_irq_agg;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n;
  logic [7:0] pin_n_i;
  logic       wr_en_i;
  logic       addr_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       irq_o;
  logic       wake_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always begin
    #5;
    if (clk_run) clk = ~clk;
  end

  lvl_irq_agg i_lvl_irq_agg (
    .clk(clk), .rst_n(rst_n), .pin_n_i(pin_n_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wdata_i = 8'h00;
  endtask

  task automatic reg_read(input logic a, input logic [7:0] exp, input string req);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pin_n_i = 8'hFF; wr_en_i = 1'b0; addr_i = 1'b0; wdata_i = 8'h00;
    cycles(3);
    chk("R1 irq in reset", {7'b0, irq_o}, 8'h00);
    reg_read(1'b0, 8'h00, "R1 enable in reset");
    rst_n = 1'b1;
    cycles(3);
    chk("R1 irq after reset", {7'b0, irq_o}, 8'h00);
    chk("R1 wake after reset", {7'b0, wake_o}, 8'h00);
    reg_read(1'b1, 8'h00, "R1 status after reset");
  endtask

  task automatic t_regmap;
    reg_write(1'b0, 8'hA5);
    reg_read(1'b0, 8'hA5, "R2 enable readback");
    reg_write(1'b0, 8'h00);
    reg_read(1'b0, 8'h00, "R2 enable cleared");
  endtask

  task automatic t_disabled;
    reg_write(1'b0, 8'h0F);
    pin_n_i = 8'h0F; // pins 7..4 low, all disabled
    cycles(6);
    chk("R3 disabled lows ignored irq", {7'b0, irq_o}, 8'h00);
    chk("R3 disabled lows no wake", {7'b0, wake_o}, 8'h00);
    reg_read(1'b1, 8'h00, "R3 status stays clear");
    pin_n_i = 8'hFF;
    reg_write(1'b0, 8'h00);
  endtask

  task automatic t_latency;
    reg_write(1'b0, 8'h01);
    pin_n_i = 8'hFE;
    #1;
    chk("R8 wake before any edge", {7'b0, wake_o}, 8'h01);
    cycles(2);
    chk("R4 irq still low after 2 edges", {7'b0, irq_o}, 8'h00);
    cycles(1);
    chk("R4 irq high after 3 edges", {7'b0, irq_o}, 8'h01);
    reg_read(1'b1, 8'h01, "R2 status bit0 only");
    pin_n_i = 8'hFF;
    cycles(3);
    chk("R7 flag holds after pin released", {7'b0, irq_o}, 8'h01);
    reg_write(1'b1, 8'h01);
    chk("R5 write one keeps flag", {7'b0, irq_o}, 8'h01);
    reg_write(1'b1, 8'hFE);
    chk("R6 write zero clears flag", {7'b0, irq_o}, 8'h00);
    chk("R8 wake drops with flag", {7'b0, wake_o}, 8'h00);
  endtask

  task automatic t_sticky_disable;
    reg_write(1'b0, 8'h04);
    pin_n_i = 8'hFB;
    cycles(4);
    chk("R4 pin2 sets flag", {7'b0, irq_o}, 8'h01);
    reg_write(1'b0, 8'h00);
    cycles(3);
    chk("R7 flag kept after disable", {7'b0, irq_o}, 8'h01);
    chk("R8 wake kept by flag", {7'b0, wake_o}, 8'h01);
    reg_write(1'b1, 8'h00);
    cycles(4);
    chk("R3 disabled low pin does not reset flag", {7'b0, irq_o}, 8'h00);
    pin_n_i = 8'hFF;
  endtask

  task automatic t_set_priority;
    reg_write(1'b0, 8'h10);
    pin_n_i = 8'hEF;
    cycles(4);
    reg_write(1'b1, 8'h00);
    chk("R9 clear while low keeps irq", {7'b0, irq_o}, 8'h01);
    cycles(3);
    chk("R9 irq still set while low", {7'b0, irq_o}, 8'h01);
    pin_n_i = 8'hFF;
    cycles(3);
    reg_write(1'b1, 8'h00);
    chk("R6 clear after cause removed", {7'b0, irq_o}, 8'h00);
    reg_write(1'b0, 8'h00);
  endtask

  task automatic t_stopped_clock;
    reg_write(1'b0, 8'h80);
    clk_run = 1'b0;
    pin_n_i = 8'h7F;
    #20;
    chk("R8 wake with clock stopped", {7'b0, wake_o}, 8'h01);
    chk("R4 no irq without clock", {7'b0, irq_o}, 8'h00);
    pin_n_i = 8'hFF;
    #20;
    chk("R8 wake falls with pin", {7'b0, wake_o}, 8'h00);
    pin_n_i = 8'h7F;
    clk_run = 1'b1;
    cycles(4);
    chk("R4 irq after clock restart", {7'b0, irq_o}, 8'h01);
    pin_n_i = 8'hFF;
    cycles(3);
    reg_write(1'b1, 8'h00);
    chk("R6 final clear", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    t_reset();
    t_regmap();
    t_disabled();
    t_latency();
    t_sticky_disable();
    t_set_priority();
    t_stopped_clock();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #200_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule